// File: doc/BRIEF.md
# Taken-Branch Target Line Cache

This block sits beside the fetch front end and keeps the first line of instruction bytes found at the targets of recently taken branches. When the front end decides that a branch is taken, it presents the branch target address. If a valid entry holds that address as its tag, the block returns the 16-byte line in the same cycle. The line can then go straight to the instruction buffer, which removes the one-clock bubble of a fresh fetch. If no entry matches, the block raises a redirect flag so that the normal fetch path supplies the bytes, and the usual one-clock penalty applies.

The store is fully associative. Each entry holds a full target-address tag, a valid bit and one line. A line is written through a fill port after a miss. A fill whose tag is already present overwrites that entry. Any other fill takes the entry chosen by a round-robin victim pointer. A flush input drops every entry at once.

The fill port is a valid/ready stream. The block accepts a fill beat in any cycle in which `fill_ready_o` is high. Back-pressure comes only from flush: while `flush_i` is high, `fill_ready_o` is low, and the producer must hold the beat until it is accepted. The lookup side has no back-pressure. Its answer is combinational and lasts only for the cycle in which the request is presented.

Top module: `tgt_line_cache`

## Requirements
- R1: After reset every entry is invalid, so every taken lookup misses until a fill is accepted.
- R2: `lu_hit_o` is high only when `lu_valid_i` and `lu_taken_i` are both high and `lu_addr_i` equals, in all 32 bits, the tag of a valid entry. In that same cycle `lu_line_o` carries the stored 128-bit line of that entry.
- R3: When `lu_valid_i` or `lu_taken_i` is low, `lu_hit_o` and `lu_redirect_o` are both low, whatever the address.
- R4: A taken, valid lookup that matches no valid entry raises `lu_redirect_o` in that cycle. `lu_hit_o` and `lu_redirect_o` are never high together.
- R5: `lu_line_o` is all zeros in every cycle in which `lu_hit_o` is low.
- R6: A fill beat is accepted at a rising edge where `fill_valid_i` and `fill_ready_o` are both high. Lookups see the new line from the next cycle on. A lookup in the same cycle as the fill sees the contents from before the fill.
- R7: An accepted fill whose tag matches no valid entry is written to the entry that the victim pointer selects. The pointer is 0 after reset and advances by one after each such fill, wrapping from 15 to 0. So the 17th fill of a new tag evicts the line written by the first of those fills.
- R8: An accepted fill whose tag matches a valid entry overwrites that entry's line and leaves the victim pointer unchanged.
- R9: A high `flush_i` invalidates every entry at the next rising edge. While `flush_i` is high, `fill_ready_o` is low and the presented fill beat is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries; blocks fills in the same cycle |
| lu_valid_i | input | 1 | Lookup request present |
| lu_taken_i | input | 1 | Request is for a branch predicted taken |
| lu_addr_i | input | 32 | Branch target address to compare |
| lu_hit_o | output | 1 | Target line found in the cache |
| lu_line_o | output | 128 | Target instruction bytes on a hit, zero otherwise |
| lu_redirect_o | output | 1 | Taken lookup missed; normal fetch must supply the target |
| fill_valid_i | input | 1 | Fill beat present |
| fill_ready_o | output | 1 | Fill beat can be accepted this cycle |
| fill_addr_i | input | 32 | Tag (target address) of the fill line |
| fill_line_i | input | 128 | Instruction bytes to store |

## Verification
Two pairs of functions can fall in the same cycle. The first is a lookup and a fill of the same target address. The bench presents both in one cycle and expects a miss with a redirect, then a hit with the new line in the following cycle. The second is a flush and a fill. The bench drives both together, expects `fill_ready_o` low in that cycle, and then confirms that the blocked address still misses. The victim order is judged by filling 16 distinct tags, adding one more, and predicting from pointer arithmetic which earlier tag must now miss. This is done across overwrites, which must not move the pointer, and across a flush.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int unsigned TLC_ENTRIES_DEF    = 16;
  localparam int unsigned TLC_ADDR_W_DEF     = 32;
  localparam int unsigned TLC_LINE_BYTES_DEF = 16;

  // classification of the fill beat presented in a cycle
  typedef enum logic [1:0] {
    FILL_IDLE      = 2'd0,
    FILL_NEW       = 2'd1,
    FILL_OVERWRITE = 2'd2,
    FILL_BLOCKED   = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/tlc_tag_match.sv
module tlc_tag_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ADDR_W-1:0]              key_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags_i,
  input  logic [ENTRIES-1:0]             valid_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [ENTRIES-1:0] match;

  // one comparator per entry; only valid entries may match
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  assign hit_o = |match;

  // tags are kept unique by the fill logic, so OR-encoding is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlc_victim_ptr.sv
module tlc_victim_ptr #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tlc_line_store.sv
module tlc_line_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_W  = 128,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_i,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [ADDR_W-1:0]              wr_tag_i,
  input  logic [LINE_W-1:0]              wr_line_i,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tags_o,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][LINE_W-1:0] lines_o
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tags_q;
  logic [ENTRIES-1:0][LINE_W-1:0] lines_q;

  // valid bits: reset and flush clear all, a write sets one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  // payload: no reset needed, guarded by the valid bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en_i && !flush_i && (wr_idx_i == IDX_W'(i))) begin
        tags_q[i]  <= wr_tag_i;
        lines_q[i] <= wr_line_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign tags_o  = tags_q;
  assign lines_o = lines_q;
endmodule

// File: rtl/tgt_line_cache.sv
module tgt_line_cache
  import tlc_pkg::*;
#(
  parameter int unsigned ENTRIES    = TLC_ENTRIES_DEF,
  parameter int unsigned ADDR_W     = TLC_ADDR_W_DEF,
  parameter int unsigned LINE_BYTES = TLC_LINE_BYTES_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic                     lu_valid_i,
  input  logic                     lu_taken_i,
  input  logic [ADDR_W-1:0]        lu_addr_i,
  output logic                     lu_hit_o,
  output logic [LINE_BYTES*8-1:0]  lu_line_o,
  output logic                     lu_redirect_o,
  input  logic                     fill_valid_i,
  output logic                     fill_ready_o,
  input  logic [ADDR_W-1:0]        fill_addr_i,
  input  logic [LINE_BYTES*8-1:0]  fill_line_i
);
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][LINE_W-1:0] lines;

  logic             lu_req;
  logic             lu_found;
  logic [IDX_W-1:0] lu_idx;
  logic             fill_found;
  logic [IDX_W-1:0] fill_idx;
  logic [IDX_W-1:0] victim_q;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  fill_kind_e       fill_kind;

  // ---------------- lookup path (combinational) ----------------
  tlc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lu_match (
    .key_i   (lu_addr_i),
    .tags_i  (tags),
    .valid_i (valid),
    .hit_o   (lu_found),
    .idx_o   (lu_idx)
  );

  assign lu_req        = lu_valid_i && lu_taken_i;
  assign lu_hit_o      = lu_req && lu_found;
  assign lu_redirect_o = lu_req && !lu_found;
  assign lu_line_o     = lu_hit_o ? lines[lu_idx] : '0;

  // ---------------- fill path ----------------
  tlc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fill_match (
    .key_i   (fill_addr_i),
    .tags_i  (tags),
    .valid_i (valid),
    .hit_o   (fill_found),
    .idx_o   (fill_idx)
  );

  assign fill_ready_o = !flush_i;

  always_comb begin
    if (!fill_valid_i)   fill_kind = FILL_IDLE;
    else if (flush_i)    fill_kind = FILL_BLOCKED;
    else if (fill_found) fill_kind = FILL_OVERWRITE;
    else                 fill_kind = FILL_NEW;
  end

  assign wr_en  = (fill_kind == FILL_NEW) || (fill_kind == FILL_OVERWRITE);
  assign wr_idx = (fill_kind == FILL_OVERWRITE) ? fill_idx : victim_q;

  tlc_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (fill_kind == FILL_NEW),
    .ptr_o (victim_q)
  );

  tlc_line_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_tag_i  (fill_addr_i),
    .wr_line_i (fill_line_i),
    .tags_o    (tags),
    .valid_o   (valid),
    .lines_o   (lines)
  );
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_W  = 128,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lu_valid,
  input logic              lu_taken,
  input logic [ADDR_W-1:0] lu_addr,
  input logic              lu_hit,
  input logic [LINE_W-1:0] lu_line,
  input logic              lu_redirect,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [LINE_W-1:0] fill_line,
  input logic              fill_hit,
  input logic [IDX_W-1:0]  victim
);
  logic fill_fire;
  logic lu_req;
  assign fill_fire = fill_valid && fill_ready;
  assign lu_req    = lu_valid && lu_taken;

  // R2
  hit_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit |-> lu_req);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_req |-> (!lu_hit && !lu_redirect));

  // R4
  hit_or_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_req |-> (lu_hit != lu_redirect));

  // R5
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_hit |-> (lu_line == '0));

  // R6
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (!(lu_req && (lu_addr == $past(fill_addr))) ||
                   (lu_hit && (lu_line == $past(fill_line)))));

  // R7
  victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !fill_hit) |=>
      (victim == (($past(victim) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victim) + IDX_W'(1))));

  // R8
  victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_fire && !fill_hit) |=> $stable(victim));

  // R9
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lu_hit);
endmodule

bind tgt_line_cache tlc_chk #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W),
  .LINE_W  (LINE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush_i),
  .lu_valid    (lu_valid_i),
  .lu_taken    (lu_taken_i),
  .lu_addr     (lu_addr_i),
  .lu_hit      (lu_hit_o),
  .lu_line     (lu_line_o),
  .lu_redirect (lu_redirect_o),
  .fill_valid  (fill_valid_i),
  .fill_ready  (fill_ready_o),
  .fill_addr   (fill_addr_i),
  .fill_line   (fill_line_i),
  .fill_hit    (fill_found),
  .victim      (victim_q)
);

// File: tb/tgt_line_cache_tb.sv
module tgt_line_cache_tb;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush_i = 1'b0;
  logic         lu_valid_i = 1'b0;
  logic         lu_taken_i = 1'b0;
  logic [31:0]  lu_addr_i = '0;
  logic         lu_hit_o;
  logic [127:0] lu_line_o;
  logic         lu_redirect_o;
  logic         fill_valid_i = 1'b0;
  logic         fill_ready_o;
  logic [31:0]  fill_addr_i = '0;
  logic [127:0] fill_line_i = '0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  tgt_line_cache u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .lu_valid_i    (lu_valid_i),
    .lu_taken_i    (lu_taken_i),
    .lu_addr_i     (lu_addr_i),
    .lu_hit_o      (lu_hit_o),
    .lu_line_o     (lu_line_o),
    .lu_redirect_o (lu_redirect_o),
    .fill_valid_i  (fill_valid_i),
    .fill_ready_o  (fill_ready_o),
    .fill_addr_i   (fill_addr_i),
    .fill_line_i   (fill_line_i)
  );

  function automatic logic [127:0] line_of(input logic [31:0] a, input logic [7:0] s);
    return {a ^ {4{s}}, ~a, a + {24'd0, s}, {s, a[23:0]}};
  endfunction

  function automatic logic [31:0] a_addr(input int i);
    return 32'h0000_4000 + 32'(i) * 32'd16;
  endfunction

  function automatic logic [31:0] d_addr(input int i);
    return 32'h0002_0000 + 32'(i) * 32'd16;
  endfunction

  task automatic chk_bit(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic chk_line(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s line: actual %h expected %h", rq, act, exp);
    end
  endtask

  // present a lookup at the falling edge, judge the same-cycle answer
  task automatic look(input string rq, input logic [31:0] a, input logic v, input logic t,
                      input logic eh, input logic [127:0] el);
    @(negedge clk);
    lu_valid_i = v;
    lu_taken_i = t;
    lu_addr_i  = a;
    #1;
    chk_bit(rq, "hit", lu_hit_o, eh);
    chk_bit(rq, "redirect", lu_redirect_o, v && t && !eh);
    chk_line(rq, lu_line_o, eh ? el : 128'd0);
  endtask

  task automatic fill(input logic [31:0] a, input logic [127:0] l);
    @(negedge clk);
    lu_valid_i   = 1'b0;
    fill_valid_i = 1'b1;
    fill_addr_i  = a;
    fill_line_i  = l;
    @(posedge clk);
    #1;
    fill_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4 R5: empty after reset, every taken lookup redirects
    for (int i = 0; i < N; i++) look("R1", a_addr(i), 1'b1, 1'b1, 1'b0, '0);
    chk_bit("R9", "fill_ready idle", fill_ready_o, 1'b1);

    // R6 R7: fill all entries, each visible afterwards
    for (int i = 0; i < N; i++) fill(a_addr(i), line_of(a_addr(i), 8'h00));
    for (int i = 0; i < N; i++) look("R2", a_addr(i), 1'b1, 1'b1, 1'b1, line_of(a_addr(i), 8'h00));
    // R2: near-miss addresses (differ in low bits) do not match
    for (int i = 0; i < N; i++) look("R2", a_addr(i) + 32'd4, 1'b1, 1'b1, 1'b0, '0);
    look("R4", 32'hFFFF_FFF0, 1'b1, 1'b1, 1'b0, '0);

    // R3: not-taken or not-valid requests stay quiet even on resident tags
    for (int i = 0; i < N; i++) look("R3", a_addr(i), 1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < N; i++) look("R3", a_addr(i), 1'b0, 1'b1, 1'b0, '0);

    // R7: 17th new tag evicts entry 0 (first fill)
    fill(32'h0000_9000, line_of(32'h0000_9000, 8'h11));
    look("R7", a_addr(0), 1'b1, 1'b1, 1'b0, '0);
    look("R7", 32'h0000_9000, 1'b1, 1'b1, 1'b1, line_of(32'h0000_9000, 8'h11));
    for (int i = 1; i < N; i++) look("R7", a_addr(i), 1'b1, 1'b1, 1'b1, line_of(a_addr(i), 8'h00));

    // R8: overwrite of a resident tag, pointer stays at 1
    fill(a_addr(5), line_of(a_addr(5), 8'h5A));
    look("R8", a_addr(5), 1'b1, 1'b1, 1'b1, line_of(a_addr(5), 8'h5A));
    look("R8", a_addr(1), 1'b1, 1'b1, 1'b1, line_of(a_addr(1), 8'h00));
    fill(32'h0000_9010, line_of(32'h0000_9010, 8'h22));
    look("R8", a_addr(1), 1'b1, 1'b1, 1'b0, '0);
    look("R8", a_addr(5), 1'b1, 1'b1, 1'b1, line_of(a_addr(5), 8'h5A));
    look("R8", a_addr(2), 1'b1, 1'b1, 1'b1, line_of(a_addr(2), 8'h00));

    // R6: lookup and fill of the same address in one cycle
    @(negedge clk);
    fill_valid_i = 1'b1;
    fill_addr_i  = 32'h0000_9020;
    fill_line_i  = line_of(32'h0000_9020, 8'h33);
    lu_valid_i   = 1'b1;
    lu_taken_i   = 1'b1;
    lu_addr_i    = 32'h0000_9020;
    #1;
    chk_bit("R6", "same-cycle hit", lu_hit_o, 1'b0);
    chk_bit("R6", "same-cycle redirect", lu_redirect_o, 1'b1);
    @(posedge clk);
    #1;
    fill_valid_i = 1'b0;
    look("R6", 32'h0000_9020, 1'b1, 1'b1, 1'b1, line_of(32'h0000_9020, 8'h33));
    look("R7", a_addr(2), 1'b1, 1'b1, 1'b0, '0);

    // R9: flush together with a fill beat
    @(negedge clk);
    lu_valid_i   = 1'b0;
    flush_i      = 1'b1;
    fill_valid_i = 1'b1;
    fill_addr_i  = 32'h0000_7700;
    fill_line_i  = line_of(32'h0000_7700, 8'h44);
    #1;
    chk_bit("R9", "fill_ready during flush", fill_ready_o, 1'b0);
    @(posedge clk);
    #1;
    flush_i      = 1'b0;
    fill_valid_i = 1'b0;
    look("R9", 32'h0000_7700, 1'b1, 1'b1, 1'b0, '0);
    for (int i = 0; i < N; i++) look("R9", a_addr(i), 1'b1, 1'b1, 1'b0, '0);
    look("R9", 32'h0000_9000, 1'b1, 1'b1, 1'b0, '0);
    look("R9", 32'h0000_9020, 1'b1, 1'b1, 1'b0, '0);

    // R7: after flush, 16 fills then one more evicts the oldest
    for (int i = 0; i < N; i++) fill(d_addr(i), line_of(d_addr(i), 8'h66));
    for (int i = 0; i < N; i++) look("R7", d_addr(i), 1'b1, 1'b1, 1'b1, line_of(d_addr(i), 8'h66));
    fill(d_addr(N), line_of(d_addr(N), 8'h77));
    look("R7", d_addr(0), 1'b1, 1'b1, 1'b0, '0);
    look("R7", d_addr(N), 1'b1, 1'b1, 1'b1, line_of(d_addr(N), 8'h77));
    look("R7", d_addr(1), 1'b1, 1'b1, 1'b1, line_of(d_addr(1), 8'h66));

    @(negedge clk);
    lu_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule